// File: doc/BRIEF.md
# Adder accuracy acceptance monitor

This block scores an approximate adder against an exact reference over a stream of trials. In every cycle where a trial is presented, it receives three inputs: the exact sum, the sum from the approximate adder, and a minimum acceptable accuracy given as an integer percentage. It takes the absolute difference between the two sums as the trial's error. It then decides whether the trial's accuracy, `(1 - error/exact) * 100%`, is strictly above the threshold.

The percentage test uses no divider. The block cross-multiplies and compares `100 * error` against `(100 - threshold) * exact`, using products wide enough that nothing is truncated. A registered accept flag appears one cycle after each trial. Two saturating counters record all trials and accepted trials. The acceptance probability is the ratio of accepted trials to all trials, and the surrounding logic reads it from these two counters.

Top module: `acc_accept_monitor`

## Requirements
- R1: `acceptValid` is 1 in the cycle after a cycle with `trialValid=1` and `clear=0`. In every other case it is 0.
- R2: `acceptFlag` is 0 whenever `acceptValid` is 0. When `acceptValid` is 1, `acceptFlag` gives the decision for the trial of the previous cycle.
- R3: The error is the absolute difference between `exactRes` and `approxRes`, whichever of the two is larger. A trial with nonzero error is accepted when `100*error < (100-t)*exactRes`, where `t` is the threshold. Both products are computed at full width, 40 bits for the defaults.
- R4: The comparison is strict. A trial whose accuracy equals the threshold exactly is rejected. For example, exact 100 against approximate 90 is rejected at `t=90` and accepted at `t=89`.
- R5: A threshold value above 100 is treated as 100, so no trial is accepted.
- R6: A trial with zero error is accepted when `t<100`. When `exactRes` is 0, the trial is accepted only if `approxRes` is also 0.
- R7: A trial whose error exceeds `exactRes` has negative accuracy and is always rejected.
- R8: `totalCount` rises by one for each counted trial. `acceptCount` rises by one for each accepted trial. Both new values are visible in the same cycle as the flag. Between trials both counts hold.
- R9: Each counter saturates at `2^CNT_W-1` and holds there.
- R10: `clear` is synchronous and takes priority over a trial. In the next cycle both counts read 0 and `acceptValid` is 0, and a trial presented together with `clear` is dropped.
- R11: While `rstN` is low at a clock edge, the counts, `acceptValid` and `acceptFlag` are all cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous clear of the counters; drops a same-cycle trial |
| trialValid | input | 1 | Qualifies a trial in this cycle |
| exactRes | input | RES_W (33) | Exact sum, unsigned |
| approxRes | input | RES_W (33) | Approximate sum, unsigned |
| minAccPct | input | PCT_W (7) | Minimum acceptable accuracy in percent; values above 100 act as 100 |
| acceptValid | output | 1 | Decision valid, one cycle after the trial |
| acceptFlag | output | 1 | Trial accepted |
| totalCount | output | CNT_W (32) | Saturating count of trials |
| acceptCount | output | CNT_W (32) | Saturating count of accepted trials |

## Verification
The bench targets the exact boundary of the strict comparison. A design that used `<=` would accept a trial whose accuracy is exactly 90% at threshold 90. It drives sums near the 33-bit maximum. A design that built the products at the operand width would wrap and accept trials with a huge error. It also covers approximate sums on both sides of the exact one, an exact result of zero, and thresholds above 100. A design that took a signed difference, treated zero error as a plain `0 < 0` comparison, or used the threshold without clamping it would mark the wrong trials. A second instance with 4-bit counters shows whether the counters wrap instead of holding, and a clear issued together with a trial shows whether that trial leaks into the counts.

// File: rtl/acc_mon_pkg.sv
package acc_mon_pkg;

  localparam int PCT_FULL = 100;

  // strobes from control to datapath
  typedef struct packed {
    logic take;  // score and count this trial
    logic wipe;  // zero counters and flag
  } monStrobe_t;

endpackage

// File: rtl/acc_mon_ctrl.sv
module acc_mon_ctrl
  import acc_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       trialValid,
  output monStrobe_t strobe,
  output logic       reportValid
);

  logic validQ;

  always_comb begin
    strobe.wipe = clear;
    strobe.take = trialValid & ~clear;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= strobe.take;
  end

  assign reportValid = validQ;

endmodule

// File: rtl/acc_mon_satcnt.sv
module acc_mon_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  logic [W-1:0] countQ;
  logic         atTop;

  assign atTop = (countQ == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN)              countQ <= '0;
    else if (clr)           countQ <= '0;
    else if (inc && !atTop) countQ <= countQ + W'(1);
  end

  assign count = countQ;

endmodule

// File: rtl/acc_mon_dp.sv
module acc_mon_dp
  import acc_mon_pkg::*;
#(
  parameter int RES_W = 33,
  parameter int PCT_W = 7,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  monStrobe_t       strobe,
  input  logic [RES_W-1:0] exactRes,
  input  logic [RES_W-1:0] approxRes,
  input  logic [PCT_W-1:0] minAccPct,
  output logic             acceptFlag,
  output logic [CNT_W-1:0] totalCount,
  output logic [CNT_W-1:0] acceptCount
);

  localparam int PROD_W = RES_W + PCT_W;
  localparam int NCNT   = 2;

  logic [RES_W-1:0]  errMag;
  logic [PCT_W-1:0]  thrClamp;
  logic [PCT_W-1:0]  marginPct;
  logic [PROD_W-1:0] errScaled;
  logic [PROD_W-1:0] exactScaled;
  logic              errZero;
  logic              trialPass;
  logic              flagQ;
  logic [NCNT-1:0]   bump;
  logic [CNT_W-1:0]  cnts [NCNT];

  // absolute error, independent of which sum is larger
  assign errMag = (exactRes >= approxRes) ? (exactRes - approxRes)
                                          : (approxRes - exactRes);

  // thresholds above full scale act as full scale
  assign thrClamp  = (minAccPct > PCT_W'(PCT_FULL)) ? PCT_W'(PCT_FULL) : minAccPct;
  assign marginPct = PCT_W'(PCT_FULL) - thrClamp;

  // cross-multiplied accuracy test at full product width
  assign errScaled   = PROD_W'(errMag) * PROD_W'(PCT_FULL);
  assign exactScaled = PROD_W'(exactRes) * PROD_W'(marginPct);
  assign errZero     = (errMag == '0);

  always_comb begin
    if (errZero) trialPass = (thrClamp != PCT_W'(PCT_FULL));
    else         trialPass = (errScaled < exactScaled);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            flagQ <= 1'b0;
    else if (strobe.take) flagQ <= trialPass;
    else                  flagQ <= 1'b0;
  end

  assign acceptFlag = flagQ;

  assign bump = {strobe.take & trialPass, strobe.take};

  for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
    acc_mon_satcnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (strobe.wipe),
      .inc   (bump[gi]),
      .count (cnts[gi])
    );
  end

  assign totalCount  = cnts[0];
  assign acceptCount = cnts[1];

endmodule

// File: rtl/acc_accept_monitor.sv
module acc_accept_monitor
  import acc_mon_pkg::*;
#(
  parameter int RES_W = 33,
  parameter int PCT_W = 7,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             trialValid,
  input  logic [RES_W-1:0] exactRes,
  input  logic [RES_W-1:0] approxRes,
  input  logic [PCT_W-1:0] minAccPct,
  output logic             acceptValid,
  output logic             acceptFlag,
  output logic [CNT_W-1:0] totalCount,
  output logic [CNT_W-1:0] acceptCount
);

  monStrobe_t strobe;

  acc_mon_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .clear       (clear),
    .trialValid  (trialValid),
    .strobe      (strobe),
    .reportValid (acceptValid)
  );

  acc_mon_dp #(
    .RES_W (RES_W),
    .PCT_W (PCT_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .exactRes    (exactRes),
    .approxRes   (approxRes),
    .minAccPct   (minAccPct),
    .acceptFlag  (acceptFlag),
    .totalCount  (totalCount),
    .acceptCount (acceptCount)
  );

endmodule

// File: rtl/acc_mon_chk.sv
module acc_mon_chk #(
  parameter int RES_W = 33,
  parameter int PCT_W = 7,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             clear,
  input logic             trialValid,
  input logic [RES_W-1:0] exactRes,
  input logic [RES_W-1:0] approxRes,
  input logic [PCT_W-1:0] minAccPct,
  input logic             acceptValid,
  input logic             acceptFlag,
  input logic [CNT_W-1:0] totalCount,
  input logic [CNT_W-1:0] acceptCount
);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trialValid && !clear) |=> acceptValid);

  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(trialValid && !clear) |=> !acceptValid);

  // R2
  flag_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    acceptFlag |-> acceptValid);

  // R5
  high_thr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trialValid && !clear && minAccPct >= PCT_W'(100)) |=> !acceptFlag);

  // R6
  exact_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trialValid && !clear && exactRes == approxRes && minAccPct < PCT_W'(100))
    |=> acceptFlag);

  // R8
  count_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    acceptCount <= totalCount);

  // R8
  count_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> totalCount >= $past(totalCount));

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (totalCount == '0 && acceptCount == '0 && !acceptValid));

endmodule

bind acc_accept_monitor acc_mon_chk #(
  .RES_W (RES_W),
  .PCT_W (PCT_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .clear       (clear),
  .trialValid  (trialValid),
  .exactRes    (exactRes),
  .approxRes   (approxRes),
  .minAccPct   (minAccPct),
  .acceptValid (acceptValid),
  .acceptFlag  (acceptFlag),
  .totalCount  (totalCount),
  .acceptCount (acceptCount)
);

// File: tb/acc_accept_monitor_tb.sv
`timescale 1ns/100ps
module acc_accept_monitor_tb;

  localparam longint unsigned RES_MAX = 64'h1_FFFF_FFFF;
  localparam longint unsigned BIG_MAX = 64'hFFFF_FFFF;
  localparam longint unsigned SML_MAX = 64'd15;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clear = 1'b0;
  logic        trialValid = 1'b0;
  logic [32:0] exactRes = '0;
  logic [32:0] approxRes = '0;
  logic [6:0]  minAccPct = '0;
  logic        acceptValid, acceptFlag;
  logic [31:0] totalCount, acceptCount;
  logic        smlValid, smlFlag;
  logic [3:0]  smlTotal, smlAccept;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  longint unsigned expTot = 0, expAcc = 0, smlTot = 0, smlAcc = 0;

  always #2.5 clk = ~clk;

  acc_accept_monitor u_dut (
    .clk(clk), .rstN(rstN), .clear(clear), .trialValid(trialValid),
    .exactRes(exactRes), .approxRes(approxRes), .minAccPct(minAccPct),
    .acceptValid(acceptValid), .acceptFlag(acceptFlag),
    .totalCount(totalCount), .acceptCount(acceptCount)
  );

  acc_accept_monitor #(.CNT_W(4)) u_dutSmall (
    .clk(clk), .rstN(rstN), .clear(clear), .trialValid(trialValid),
    .exactRes(exactRes), .approxRes(approxRes), .minAccPct(minAccPct),
    .acceptValid(smlValid), .acceptFlag(smlFlag),
    .totalCount(smlTotal), .acceptCount(smlAccept)
  );

  function automatic bit modelPass(longint unsigned ex, longint unsigned ap, int unsigned t);
    longint unsigned err = (ex >= ap) ? ex - ap : ap - ex;
    longint unsigned tc = (t > 100) ? 100 : t;
    if (err == 0) return tc < 100;
    return (err * 100) < ((100 - tc) * ex);
  endfunction

  function automatic longint unsigned satInc(longint unsigned v, longint unsigned mx);
    return (v < mx) ? v + 1 : v;
  endfunction

  task automatic chk(string tag, string what, longint unsigned act, longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkCounts(string tag);
    chk(tag, "totalCount", totalCount, expTot);
    chk(tag, "acceptCount", acceptCount, expAcc);
    chk("R9", "small totalCount", smlTotal, smlTot);
    chk("R9", "small acceptCount", smlAccept, smlAcc);
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic runTrial(longint unsigned ex, longint unsigned ap, int unsigned t, string tag);
    bit p;
    exactRes = ex[32:0];
    approxRes = ap[32:0];
    minAccPct = t[6:0];
    trialValid = 1'b1;
    @(negedge clk);
    trialValid = 1'b0;
    p = modelPass(ex, ap, t);
    expTot = satInc(expTot, BIG_MAX);
    smlTot = satInc(smlTot, SML_MAX);
    if (p) begin
      expAcc = satInc(expAcc, BIG_MAX);
      smlAcc = satInc(smlAcc, SML_MAX);
    end
    chk("R1", "acceptValid", acceptValid, 1);
    chk(tag, "acceptFlag", acceptFlag, p);
    chk("R2", "small acceptFlag", smlFlag, p);
    checkCounts("R8");
  endtask

  task automatic idleCycle();
    trialValid = 1'b0;
    @(negedge clk);
    chk("R1", "acceptValid idle", acceptValid, 0);
    chk("R2", "acceptFlag idle", acceptFlag, 0);
    checkCounts("R8");
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "acceptValid reset", acceptValid, 0);
    chk("R11", "acceptFlag reset", acceptFlag, 0);
    chk("R11", "totalCount reset", totalCount, 0);
    chk("R11", "acceptCount reset", acceptCount, 0);
    rstN = 1'b1;
    idleCycle();

    // R4 strict boundary
    runTrial(100, 90, 90, "R4");
    runTrial(100, 90, 89, "R4");
    // R3 both sides of the exact sum
    runTrial(1000, 1050, 90, "R3");
    runTrial(1000, 950, 90, "R3");
    // R3 full-width products near the top of the range
    runTrial(RES_MAX, RES_MAX - 1, 99, "R3");
    runTrial(RES_MAX, 0, 0, "R3");
    runTrial(RES_MAX, RES_MAX / 2, 49, "R3");
    runTrial(RES_MAX / 2, RES_MAX, 0, "R7");
    // R6 zero error and zero exact
    runTrial(0, 0, 50, "R6");
    runTrial(0, 0, 100, "R6");
    runTrial(0, 1, 0, "R6");
    runTrial(77, 77, 99, "R6");
    // R5 thresholds above full scale
    runTrial(5, 5, 120, "R5");
    runTrial(1000, 1001, 127, "R5");
    // R7 negative accuracy
    runTrial(10, 25, 0, "R7");
    idleCycle();

    // R9 the small counters have saturated by now
    repeat (20) runTrial(8, 8, 10, "R9");
    chk("R9", "small total held at max", smlTotal, 15);

    // R10 clear with a same-cycle trial
    exactRes = 33'd9; approxRes = 33'd9; minAccPct = 7'd0;
    trialValid = 1'b1; clear = 1'b1;
    @(negedge clk);
    clear = 1'b0; trialValid = 1'b0;
    expTot = 0; expAcc = 0; smlTot = 0; smlAcc = 0;
    chk("R10", "acceptValid after clear", acceptValid, 0);
    checkCounts("R10");

    // constrained random stream
    for (int i = 0; i < 3000; i++) begin
      longint unsigned ex, ap, d;
      int unsigned t, mode;
      mode = $urandom % 5;
      ex = {$urandom, $urandom} & RES_MAX;
      if (mode == 0) ex = ex & 64'hFF;
      d = {$urandom, $urandom} % ((ex >> ($urandom % 12)) + 1);
      if ($urandom % 2) ap = (ex + d) & RES_MAX;
      else              ap = (ex >= d) ? ex - d : 0;
      if (mode == 4) ap = {$urandom, $urandom} & RES_MAX;
      t = $urandom % 128;
      runTrial(ex, ap, t, "R3");
      if ($urandom % 8 == 0) idleCycle();
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule